// File: doc/BRIEF.md
# Saturating Charge-Cycle Counter with Hysteresis

This block counts how many valid charge events a battery has seen since its learned full capacity was last re-learned. Each count is one step closer to distrust of the learned value. Once the count climbs high enough, the block raises a capacity-inaccurate flag. The counter stops at its top value and does not wrap.

A trickle charger held near full would otherwise add a count every time self-discharge nudged the remaining capacity down. To prevent this, a hysteresis latch watches a near-full threshold of 15/16 of the learned capacity, which is computed with a multiply and a shift. Above that threshold only one charge event is counted, and the next one counts only after the remaining capacity has fallen to or below the threshold.

The block also decides when a capacity re-learn may happen. It arms when the remaining capacity equals the learned capacity. It fires a one-cycle update strobe when the end-of-discharge indication rises, provided three things hold: no charge arrived since arming, the temperature is not below zero, and the self-discharge count is under its limit. That strobe clears the count and the flag. A soft-reset strobe clears the count but sets the flag.

Top module: `chg_cycle_tracker`

## Requirements
- R1: When `chg_evt` is high and `rem_cap` is at or below `(learn_cap*15)>>4`, `cycle_cnt` is one higher after the next rising clock edge.
- R2: When `rem_cap` is strictly above that limit, only the first `chg_evt` is counted. Later ones are ignored until a cycle in which `rem_cap` is at or below the limit.
- R3: `cycle_cnt` holds at 255 on further counted events and never wraps to 0.
- R4: `cap_inacc` goes high on the edge at which `cycle_cnt` becomes 64 through a count. It then stays high until a learn strobe clears it.
- R5: In the cycle after `learn_upd` is high, `cycle_cnt` reads 0 and `cap_inacc` reads 0.
- R6: The block arms when `rem_cap == learn_cap`. A rising `edv_hit` while armed makes `learn_upd` high for exactly one cycle, on the edge after the rise is seen. A `chg_evt` after arming cancels the arming, so no strobe follows.
- R7: No strobe is issued at the `edv_hit` rise if `temp_neg` is high or `sd_count` is 4096 or more. A `sd_count` of 4095 still allows it.
- R8: `soft_rst` makes `cycle_cnt` 0 and `cap_inacc` 1 on the next edge. It also cancels the arming and the hysteresis latch, and it takes priority over counting.
- R9: While `rst_n` is low, `cycle_cnt` is 0, `cap_inacc` is 1 and `learn_upd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Single-cycle soft reset strobe |
| chg_evt | input | 1 | Single-cycle valid-charge event |
| rem_cap | input | 16 | Present remaining capacity |
| learn_cap | input | 16 | Present learned full capacity |
| edv_hit | input | 1 | End-of-discharge indication (level) |
| temp_neg | input | 1 | High when temperature is below 0 degrees |
| sd_count | input | 16 | Self-discharge count |
| cycle_cnt | output | 8 | Saturating charge-cycle count |
| cap_inacc | output | 1 | Capacity-inaccurate flag |
| learn_upd | output | 1 | One-cycle learn-update strobe |

## Verification
The assertions check these properties on every cycle:
- the single-step increment;
- the hold at 255;
- the flag trip at 64;
- the clear after a strobe and after a soft reset;
- the strobe lasting one cycle and only appearing with its qualifiers met;
- the latch blocking a second count above the threshold.

Some behaviours show up only across several cycles, and only the bench scenarios exercise them:
- the exact threshold boundary at equality;
- the release of the latch once the capacity drops;
- a charge cancelling an earlier arming;
- the 4095/4096 edge of the self-discharge qualifier.

// File: rtl/chg_cycle_pkg.sv
package chg_cycle_pkg;
  typedef enum logic [0:0] {
    LQ_IDLE  = 1'b0,
    LQ_ARMED = 1'b1
  } learn_state_t;
endpackage

// File: rtl/chg_near_full_gate.sv
module chg_near_full_gate #(
  parameter int CAP_W = 16,
  parameter int NUM   = 15,
  parameter int SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             chg_evt,
  input  logic [CAP_W-1:0] rem_cap,
  input  logic [CAP_W-1:0] learn_cap,
  output logic             above,
  output logic             bump,
  output logic             hold_off
);
  localparam int PW = CAP_W + SHIFT;

  // near-full limit: cap * NUM / 2^SHIFT, no divider
  function automatic logic [CAP_W-1:0] scaled_limit(input logic [CAP_W-1:0] cap);
    logic [PW-1:0] prod;
    prod = PW'(cap) * PW'(NUM);
    return prod[PW-1:SHIFT];
  endfunction

  logic [CAP_W-1:0] limit;

  always_comb begin
    limit = scaled_limit(learn_cap);
    above = rem_cap > limit;
    bump  = chg_evt && !soft_rst && (!above || !hold_off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hold_off <= 1'b0;
    else if (soft_rst)      hold_off <= 1'b0;
    else if (!above)        hold_off <= 1'b0;
    else if (chg_evt)       hold_off <= 1'b1;
  end

  // latch arms after a charge seen above the limit
  assert_latch_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_evt && above && !soft_rst) |=> hold_off);
  // latch never survives a cycle at or below the limit
  assert_latch_rel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!above) |=> !hold_off);
endmodule

// File: rtl/chg_tally_sat.sv
module chg_tally_sat #(
  parameter int CNT_W = 8,
  parameter int TRIP  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             clr,
  input  logic             bump,
  output logic [CNT_W-1:0] cnt,
  output logic             ci
);
  localparam logic [CNT_W-1:0] MAXV  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TRIPV = CNT_W'(TRIP);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == MAXV) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] nxt;
  logic             at_top;
  logic             hits_trip;

  always_comb begin
    nxt       = sat_inc(cnt);
    at_top    = cnt == MAXV;
    hits_trip = bump && !at_top && nxt == TRIPV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ci  <= 1'b1;
    end else if (soft_rst) begin
      cnt <= '0;
      ci  <= 1'b1;
    end else if (clr) begin
      cnt <= '0;
      ci  <= 1'b0;
    end else if (bump) begin
      cnt <= nxt;
      if (hits_trip) ci <= 1'b1;
    end
  end

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !clr && !soft_rst && cnt != MAXV) |=> cnt == $past(cnt) + 1'b1);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !clr && !soft_rst) |=> cnt == MAXV);
  assert_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !clr && !soft_rst && cnt == TRIPV - 1'b1) |=> ci);
  assert_ci_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ci && !clr) |=> ci);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !soft_rst) |=> (cnt == '0 && !ci));
  assert_soft_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cnt == '0 && ci));
endmodule

// File: rtl/chg_learn_qual.sv
module chg_learn_qual
  import chg_cycle_pkg::*;
#(
  parameter int CAP_W    = 16,
  parameter int SD_W     = 16,
  parameter int SD_LIMIT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             chg_evt,
  input  logic [CAP_W-1:0] rem_cap,
  input  logic [CAP_W-1:0] learn_cap,
  input  logic             edv_hit,
  input  logic             temp_neg,
  input  logic [SD_W-1:0]  sd_count,
  output logic             learn_upd,
  output logic             edv_rise,
  output logic             armed
);
  localparam logic [SD_W-1:0] SDL = SD_W'(SD_LIMIT);

  learn_state_t st;
  logic         edv_q;
  logic         quals_ok;
  logic         fire;

  always_comb begin
    armed    = st == LQ_ARMED;
    edv_rise = edv_hit && !edv_q;
    quals_ok = !temp_neg && (sd_count < SDL) && !chg_evt;
    fire     = armed && edv_rise && quals_ok && !soft_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LQ_IDLE;
      edv_q     <= 1'b0;
      learn_upd <= 1'b0;
    end else begin
      edv_q     <= edv_hit;
      learn_upd <= fire;
      if (soft_rst || chg_evt || edv_rise) st <= LQ_IDLE;
      else if (rem_cap == learn_cap)       st <= LQ_ARMED;
    end
  end

  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    learn_upd |=> !learn_upd);
  assert_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    learn_upd |-> $past(edv_hit && armed && !chg_evt));
  assert_quals_R7: assert property (@(posedge clk) disable iff (!rst_n)
    learn_upd |-> $past(!temp_neg && sd_count < SDL));
endmodule

// File: rtl/chg_cycle_tracker.sv
module chg_cycle_tracker #(
  parameter int CAP_W    = 16,
  parameter int CNT_W    = 8,
  parameter int TRIP     = 64,
  parameter int SD_W     = 16,
  parameter int SD_LIMIT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             chg_evt,
  input  logic [CAP_W-1:0] rem_cap,
  input  logic [CAP_W-1:0] learn_cap,
  input  logic             edv_hit,
  input  logic             temp_neg,
  input  logic [SD_W-1:0]  sd_count,
  output logic [CNT_W-1:0] cycle_cnt,
  output logic             cap_inacc,
  output logic             learn_upd
);
  logic above_w, bump_w, hold_w, rise_w, armed_w;

  chg_near_full_gate #(.CAP_W(CAP_W), .NUM(15), .SHIFT(4)) u_gate (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .chg_evt(chg_evt),
    .rem_cap(rem_cap), .learn_cap(learn_cap),
    .above(above_w), .bump(bump_w), .hold_off(hold_w)
  );

  chg_learn_qual #(.CAP_W(CAP_W), .SD_W(SD_W), .SD_LIMIT(SD_LIMIT)) u_qual (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .chg_evt(chg_evt),
    .rem_cap(rem_cap), .learn_cap(learn_cap), .edv_hit(edv_hit),
    .temp_neg(temp_neg), .sd_count(sd_count),
    .learn_upd(learn_upd), .edv_rise(rise_w), .armed(armed_w)
  );

  chg_tally_sat #(.CNT_W(CNT_W), .TRIP(TRIP)) u_tally (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clr(learn_upd),
    .bump(bump_w), .cnt(cycle_cnt), .ci(cap_inacc)
  );

  // latched and still above: count must be frozen
  assert_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_w && above_w && !learn_upd && !soft_rst) |=> cycle_cnt == $past(cycle_cnt));
  // a charge while armed drops the arming
  assert_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_w && chg_evt) |=> !learn_upd);
  assert_soft_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!armed_w && !hold_w));
  always_comb begin
    if (!rst_n) assert_reset_R9: assert (!learn_upd);
  end
endmodule

// File: tb/tb_chg_cycle_tracker.sv
module tb_chg_cycle_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        chg_evt = 1'b0;
  logic [15:0] rem_cap = 16'd0;
  logic [15:0] learn_cap = 16'd1000;
  logic        edv_hit = 1'b0;
  logic        temp_neg = 1'b0;
  logic [15:0] sd_count = 16'd0;
  logic [7:0]  cycle_cnt;
  logic        cap_inacc;
  logic        learn_upd;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chg_cycle_tracker dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .chg_evt(chg_evt),
    .rem_cap(rem_cap), .learn_cap(learn_cap), .edv_hit(edv_hit),
    .temp_neg(temp_neg), .sd_count(sd_count),
    .cycle_cnt(cycle_cnt), .cap_inacc(cap_inacc), .learn_upd(learn_upd)
  );

  // {rem_cap, chg_evt, expected count}; learn_cap = 1000 -> limit 937
  localparam logic [31:0] VEC [12] = '{
    {16'd500, 8'd1, 8'd1}, {16'd500, 8'd1, 8'd2}, {16'd937, 8'd1, 8'd3},
    {16'd938, 8'd1, 8'd4}, {16'd938, 8'd1, 8'd4}, {16'd990, 8'd1, 8'd4},
    {16'd990, 8'd0, 8'd4}, {16'd937, 8'd0, 8'd4}, {16'd950, 8'd1, 8'd5},
    {16'd950, 8'd1, 8'd5}, {16'd100, 8'd0, 8'd5}, {16'd100, 8'd1, 8'd6}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns after the rising edge
  task automatic step(input logic c);
    @(negedge clk);
    chg_evt = c;
    @(posedge clk);
    #1;
    chg_evt = 1'b0;
  endtask

  task automatic arm_and_discharge(input logic cancel);
    step(1'b0);
    @(negedge clk); rem_cap = learn_cap;
    @(posedge clk); #1;
    @(negedge clk); rem_cap = 16'd50;
    if (cancel) chg_evt = 1'b1;
    @(posedge clk); #1;
    chg_evt = 1'b0;
    @(negedge clk); edv_hit = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 count in reset", int'(cycle_cnt), 0);
    chk("R9 flag in reset", int'(cap_inacc), 1);
    chk("R9 strobe in reset", int'(learn_upd), 0);
    @(negedge clk); rst_n = 1'b1;

    foreach (VEC[i]) begin
      @(negedge clk);
      rem_cap = VEC[i][31:16];
      chg_evt = VEC[i][8];
      @(posedge clk); #1;
      chg_evt = 1'b0;
      chk($sformatf("R1/R2 vector %0d", i), int'(cycle_cnt), int'(VEC[i][7:0]));
    end

    // learn update: strobe seen one edge after rise, clear one edge later (R6, R5)
    arm_and_discharge(1'b0);
    chk("R6 strobe high", int'(learn_upd), 1);
    chk("R6 count before clear", int'(cycle_cnt), 6);
    @(posedge clk); #1;
    chk("R6 strobe one cycle", int'(learn_upd), 0);
    chk("R5 count cleared", int'(cycle_cnt), 0);
    chk("R5 flag cleared", int'(cap_inacc), 0);
    @(negedge clk); edv_hit = 1'b0;

    // flag trip at 64 (R4)
    rem_cap = 16'd100;
    for (int k = 0; k < 63; k++) step(1'b1);
    chk("R4 count 63", int'(cycle_cnt), 63);
    chk("R4 flag low at 63", int'(cap_inacc), 0);
    step(1'b1);
    chk("R4 count 64", int'(cycle_cnt), 64);
    chk("R4 flag set at 64", int'(cap_inacc), 1);
    // saturation (R3)
    for (int k = 0; k < 200; k++) step(1'b1);
    chk("R3 saturated", int'(cycle_cnt), 255);
    chk("R4 flag still set", int'(cap_inacc), 1);

    // soft reset with a charge pending (R8)
    @(negedge clk); soft_rst = 1'b1; chg_evt = 1'b1;
    @(posedge clk); #1;
    soft_rst = 1'b0; chg_evt = 1'b0;
    chk("R8 count zero", int'(cycle_cnt), 0);
    chk("R8 flag set", int'(cap_inacc), 1);

    // charge after arming cancels (R6)
    arm_and_discharge(1'b1);
    chk("R6 cancelled no strobe", int'(learn_upd), 0);
    chk("R1 cancel charge counted", int'(cycle_cnt), 1);
    @(posedge clk); #1;
    chk("R6 cancelled no clear", int'(cycle_cnt), 1);
    @(negedge clk); edv_hit = 1'b0;

    // temperature below zero blocks (R7)
    temp_neg = 1'b1;
    arm_and_discharge(1'b0);
    chk("R7 cold blocks", int'(learn_upd), 0);
    @(negedge clk); edv_hit = 1'b0; temp_neg = 1'b0;

    // self-discharge 4096 blocks, 4095 allows (R7)
    sd_count = 16'd4096;
    arm_and_discharge(1'b0);
    chk("R7 sd 4096 blocks", int'(learn_upd), 0);
    @(negedge clk); edv_hit = 1'b0;
    sd_count = 16'd4095;
    arm_and_discharge(1'b0);
    chk("R7 sd 4095 allows", int'(learn_upd), 1);
    @(posedge clk); #1;
    chk("R5 cleared after strobe", int'(cycle_cnt), 0);
    @(negedge clk); edv_hit = 1'b0;

    // soft reset drops the latch: above limit counts again at once (R8)
    rem_cap = 16'd950;
    step(1'b1);
    step(1'b1);
    chk("R2 latched above", int'(cycle_cnt), 1);
    @(negedge clk); soft_rst = 1'b1;
    @(posedge clk); #1; soft_rst = 1'b0;
    step(1'b1);
    chk("R8 latch released", int'(cycle_cnt), 1);

    // soft reset cancels arming (R8)
    step(1'b0);
    @(negedge clk); rem_cap = learn_cap;
    @(posedge clk); #1;
    @(negedge clk); rem_cap = 16'd50; soft_rst = 1'b1;
    @(posedge clk); #1; soft_rst = 1'b0;
    @(negedge clk); edv_hit = 1'b1;
    @(posedge clk); #1;
    chk("R8 arming cancelled", int'(learn_upd), 0);
    @(negedge clk); edv_hit = 1'b0;

    // hard reset mid-run (R9)
    step(1'b1);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R9 async count", int'(cycle_cnt), 0);
    chk("R9 async flag", int'(cap_inacc), 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule